// File: doc/BRIEF.md
# Serializer Data Port Sequencer

This block lets a host bus (DMA engine or processor) service up to sixteen audio serializer buffers through one fixed data location. A write always goes to a transmit buffer and a read always comes from a receive buffer. The hardware picks the buffer itself. Within each time slot, successive writes land in the active transmit serializers from the lowest index upward and skip the inactive ones. Successive reads return the active receive serializers in the same ascending order.

A transmit slot begins with a `txSlotStart` pulse. On that pulse the block computes the transmit active set: every serializer whose transmit enable is set, provided the current slot is selected in the transmit slot mask. This set then governs the host writes until the next pulse. An `rxCapture` pulse does the same on the receive side. It also loads new serializer data into the active receive buffers. Each pulse produces a ready event one cycle later.

The block raises sticky error flags when the host falls behind. A transmit underrun is flagged when a slot ends before every active transmit serializer was written. A receive overrun is flagged when new receive data arrives before every active receive serializer was read. An access error is flagged for a port access beyond the active set. Each flag has its own write-one-to-clear input. When the bus-select input is 1, the port is switched off and host accesses do nothing.

Top module: `ser_port_seq`

## Requirements
- R1: A host write (`hostWrEn`) changes only the transmit buffers. A host read (`hostRdEn`) returns data from the receive buffers on `hostRdData`, with `hostRdValid` high, in the cycle after the read request.
- R2: Serializer i is in the transmit active set when `txSerEn[i]` is 1 and `txSlotMask[txSlot]` is 1, both sampled at `txSlotStart`. Within the slot, the k-th write stores its data in the k-th lowest index of that set. Transmit buffer i appears at `txBufFlat[i*DATA_W +: DATA_W]`.
- R3: On `rxCapture`, every serializer i with `rxSerEn[i]` = 1 and `rxSlotMask[rxSlot]` = 1 loads `rxBufIn[i*DATA_W +: DATA_W]`. The k-th read that follows returns the buffer with the k-th lowest index in that set.
- R4: When the current slot's bit in a slot mask is 0, the active set for that slot is empty, regardless of the serializer enables.
- R5: If a `txSlotStart` arrives while part of the previous transmit active set is still unwritten, `txUnderrun` becomes 1 in the next cycle.
- R6: If an `rxCapture` arrives while part of the previous receive active set is still unread, `rxOverrun` becomes 1 in the next cycle.
- R7: A write beyond the active set is dropped and leaves every buffer unchanged. A read beyond the active set returns zero. Either one sets `accessErr`.
- R8: While `busSel` is 1, host reads and writes have no effect: no buffer change, no ordering advance, no `hostRdValid` and no error.
- R9: `txReady` pulses for exactly one cycle, one cycle after `txSlotStart`. `rxReady` does the same after `rxCapture`. Each pulse restarts the ordering from the lowest active index.
- R10: The three error flags stay at 1 until a 1 is applied to their clear input. If a set and a clear fall in the same cycle, the set wins.
- R11: After reset, all buffers, `hostRdData`, the flags, the ready pulses and `hostRdValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | 1 disables the data port |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | DATA_W | Host write data |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | DATA_W | Read data, registered |
| hostRdValid | output | 1 | Read data valid, one cycle after hostRdEn |
| txSlotStart | input | 1 | Transmit slot boundary pulse |
| txSlot | input | SLOT_W | Current transmit slot index |
| txSlotMask | input | NUM_SLOT | Transmit slot selection mask |
| txSerEn | input | 16 | Per-serializer transmit enable |
| txReady | output | 1 | Transmit data-ready event |
| txBufFlat | output | 16*DATA_W | All transmit buffers, serializer i at slice i |
| rxCapture | input | 1 | Receive data arrival pulse |
| rxSlot | input | SLOT_W | Current receive slot index |
| rxSlotMask | input | NUM_SLOT | Receive slot selection mask |
| rxSerEn | input | 16 | Per-serializer receive enable |
| rxBufIn | input | 16*DATA_W | Incoming receive words, serializer i at slice i |
| rxReady | output | 1 | Receive data-ready event |
| txUnderrun | output | 1 | Sticky transmit underrun flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |
| accessErr | output | 1 | Sticky access-beyond-active-set flag |
| txUnderrunClr | input | 1 | Clears txUnderrun |
| rxOverrunClr | input | 1 | Clears rxOverrun |
| accessErrClr | input | 1 | Clears accessErr |

## Verification
The properties assume that the host never issues a write in the same cycle as `txSlotStart`, nor a read in the same cycle as `rxCapture`. The block drops such accesses silently. The stimulus therefore places slot pulses and host accesses on separate cycles. It also assumes that the slot indexes stay below `NUM_SLOT`, so the stimulus draws slot numbers only from that range. Sparse random enables, masks and bus-select values, with host access counts one short of, equal to or one beyond the active set, keep every ordering and error path within those limits.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int unsigned SER_COUNT = 16;
  localparam int unsigned IDX_W = $clog2(SER_COUNT);

  typedef struct packed {
    logic txWr;
    logic [IDX_W-1:0] txIdx;
    logic rxRd;
    logic rxHit;
    logic [IDX_W-1:0] rxIdx;
    logic rxCap;
    logic [SER_COUNT-1:0] rxCapMask;
  } portStrobe_t;

  // lowest set index of a mask, 0 when empty
  function automatic logic [IDX_W-1:0] lowestIdx(input logic [SER_COUNT-1:0] m);
    lowestIdx = '0;
    for (int i = SER_COUNT - 1; i >= 0; i--) begin
      if (m[i]) lowestIdx = IDX_W'(i);
    end
  endfunction
endpackage

// File: rtl/ser_port_ctrl.sv
module ser_port_ctrl
  import ser_port_pkg::*;
#(
  parameter int unsigned NUM_SLOT = 32,
  parameter int unsigned SLOT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 hostWrEn,
  input  logic                 hostRdEn,
  input  logic                 txSlotStart,
  input  logic [SLOT_W-1:0]    txSlot,
  input  logic [NUM_SLOT-1:0]  txSlotMask,
  input  logic [SER_COUNT-1:0] txSerEn,
  input  logic                 rxCapture,
  input  logic [SLOT_W-1:0]    rxSlot,
  input  logic [NUM_SLOT-1:0]  rxSlotMask,
  input  logic [SER_COUNT-1:0] rxSerEn,
  input  logic                 txUnderrunClr,
  input  logic                 rxOverrunClr,
  input  logic                 accessErrClr,
  output portStrobe_t          strb,
  output logic                 hostRdValid,
  output logic                 txReady,
  output logic                 rxReady,
  output logic                 txUnderrun,
  output logic                 rxOverrun,
  output logic                 accessErr
);
  logic [SER_COUNT-1:0] txRemain, rxRemain;
  logic [SER_COUNT-1:0] txSet, rxSet;
  logic portOn, wrGo, rdGo, txAny, rxAny;
  logic underSet, overSet, accSet;

  assign txSet  = txSerEn & {SER_COUNT{txSlotMask[txSlot]}};
  assign rxSet  = rxSerEn & {SER_COUNT{rxSlotMask[rxSlot]}};
  assign portOn = !busSel;
  assign wrGo   = portOn && hostWrEn && !txSlotStart;
  assign rdGo   = portOn && hostRdEn && !rxCapture;
  assign txAny  = |txRemain;
  assign rxAny  = |rxRemain;

  assign underSet = txSlotStart && txAny;
  assign overSet  = rxCapture && rxAny;
  assign accSet   = (wrGo && !txAny) || (rdGo && !rxAny);

  always_comb begin
    strb           = '0;
    strb.txWr      = wrGo && txAny;
    strb.txIdx     = lowestIdx(txRemain);
    strb.rxRd      = rdGo;
    strb.rxHit     = rxAny;
    strb.rxIdx     = lowestIdx(rxRemain);
    strb.rxCap     = rxCapture;
    strb.rxCapMask = rxSet;
  end

  // remaining-to-service masks; clearing the lowest set bit walks upward
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRemain <= '0;
      rxRemain <= '0;
    end else begin
      if (txSlotStart)        txRemain <= txSet;
      else if (wrGo && txAny) txRemain <= txRemain & (txRemain - 1'b1);
      if (rxCapture)          rxRemain <= rxSet;
      else if (rdGo && rxAny) rxRemain <= rxRemain & (rxRemain - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReady     <= 1'b0;
      rxReady     <= 1'b0;
      hostRdValid <= 1'b0;
      txUnderrun  <= 1'b0;
      rxOverrun   <= 1'b0;
      accessErr   <= 1'b0;
    end else begin
      txReady     <= txSlotStart;
      rxReady     <= rxCapture;
      hostRdValid <= rdGo;
      if (underSet)           txUnderrun <= 1'b1;
      else if (txUnderrunClr) txUnderrun <= 1'b0;
      if (overSet)            rxOverrun <= 1'b1;
      else if (rxOverrunClr)  rxOverrun <= 1'b0;
      if (accSet)             accessErr <= 1'b1;
      else if (accessErrClr)  accessErr <= 1'b0;
    end
  end

  // R5: unfinished transmit slot raises the underrun flag
  a_r5_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (txSlotStart && txRemain != '0) |=> txUnderrun);

  // R6: unread receive data overwritten raises the overrun flag
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (rxCapture && rxRemain != '0) |=> rxOverrun);

  // R10: flags hold until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrun && !txUnderrunClr) |=> txUnderrun);

  // R8: disabled port does not advance the ordering
  a_r8_port_off: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !txSlotStart) |=> $stable(txRemain));

  // R2: each serviced write retires exactly one serializer
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !busSel && !txSlotStart && txRemain != '0)
      |=> ($countones(txRemain) + 1 == $countones($past(txRemain))));

  // R9: ready follows the slot pulse by one cycle
  a_r9_ready: assert property (@(posedge clk) disable iff (!rstN)
    rxCapture |=> rxReady);
endmodule

// File: rtl/ser_port_dp.sv
module ser_port_dp
  import ser_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  portStrobe_t                   strb,
  input  logic [DATA_W-1:0]             hostWrData,
  input  logic [SER_COUNT*DATA_W-1:0]   rxBufIn,
  output logic [SER_COUNT*DATA_W-1:0]   txBufFlat,
  output logic [DATA_W-1:0]             hostRdData
);
  logic [DATA_W-1:0] txBuf [SER_COUNT];
  logic [DATA_W-1:0] rxBuf [SER_COUNT];

  for (genvar g = 0; g < SER_COUNT; g++) begin : gSer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txBuf[g] <= '0;
      end else if (strb.txWr && strb.txIdx == IDX_W'(g)) begin
        txBuf[g] <= hostWrData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxBuf[g] <= '0;
      end else if (strb.rxCap && strb.rxCapMask[g]) begin
        rxBuf[g] <= rxBufIn[g*DATA_W +: DATA_W];
      end
    end

    assign txBufFlat[g*DATA_W +: DATA_W] = txBuf[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (strb.rxRd) begin
      hostRdData <= strb.rxHit ? rxBuf[strb.rxIdx] : '0;
    end
  end

  // R2: a steered write lands in the selected transmit buffer
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.txWr |=> (txBufFlat[$past(strb.txIdx)*DATA_W +: DATA_W] == $past(hostWrData)));

  // R7: a read beyond the active set returns zero
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxRd && !strb.rxHit) |=> (hostRdData == '0));
endmodule

// File: rtl/ser_port_seq.sv
module ser_port_seq
  import ser_port_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_SLOT = 32,
  localparam int unsigned NUM_SER = SER_COUNT,
  localparam int unsigned SLOT_W = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busSel,
  input  logic                        hostWrEn,
  input  logic [DATA_W-1:0]           hostWrData,
  input  logic                        hostRdEn,
  output logic [DATA_W-1:0]           hostRdData,
  output logic                        hostRdValid,
  input  logic                        txSlotStart,
  input  logic [SLOT_W-1:0]           txSlot,
  input  logic [NUM_SLOT-1:0]         txSlotMask,
  input  logic [NUM_SER-1:0]          txSerEn,
  output logic                        txReady,
  output logic [NUM_SER*DATA_W-1:0]   txBufFlat,
  input  logic                        rxCapture,
  input  logic [SLOT_W-1:0]           rxSlot,
  input  logic [NUM_SLOT-1:0]         rxSlotMask,
  input  logic [NUM_SER-1:0]          rxSerEn,
  input  logic [NUM_SER*DATA_W-1:0]   rxBufIn,
  output logic                        rxReady,
  output logic                        txUnderrun,
  output logic                        rxOverrun,
  output logic                        accessErr,
  input  logic                        txUnderrunClr,
  input  logic                        rxOverrunClr,
  input  logic                        accessErrClr
);
  portStrobe_t strb;

  ser_port_ctrl #(.NUM_SLOT(NUM_SLOT), .SLOT_W(SLOT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .txSlotStart(txSlotStart), .txSlot(txSlot), .txSlotMask(txSlotMask), .txSerEn(txSerEn),
    .rxCapture(rxCapture), .rxSlot(rxSlot), .rxSlotMask(rxSlotMask), .rxSerEn(rxSerEn),
    .txUnderrunClr(txUnderrunClr), .rxOverrunClr(rxOverrunClr), .accessErrClr(accessErrClr),
    .strb(strb), .hostRdValid(hostRdValid), .txReady(txReady), .rxReady(rxReady),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun), .accessErr(accessErr)
  );

  ser_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .rxBufIn(rxBufIn), .txBufFlat(txBufFlat), .hostRdData(hostRdData)
  );
endmodule

// File: tb/sim_ser_port_seq.sv
`timescale 1ns/1ps
module sim_ser_port_seq;
  localparam int DW = 32;
  localparam int NS = 16;
  localparam int NSLOT = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic busSel = 1'b0, hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [DW-1:0] hostWrData = '0;
  logic [DW-1:0] hostRdData;
  logic hostRdValid, txReady, rxReady, txUnderrun, rxOverrun, accessErr;
  logic txSlotStart = 1'b0, rxCapture = 1'b0;
  logic [SW-1:0] txSlot = '0, rxSlot = '0;
  logic [NSLOT-1:0] txSlotMask = '0, rxSlotMask = '0;
  logic [NS-1:0] txSerEn = '0, rxSerEn = '0;
  logic [NS*DW-1:0] txBufFlat;
  logic [NS*DW-1:0] rxBufIn = '0;
  logic txUnderrunClr = 1'b0, rxOverrunClr = 1'b0, accessErrClr = 1'b0;

  ser_port_seq #(.DATA_W(DW), .NUM_SLOT(NSLOT)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdEn(hostRdEn),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid),
    .txSlotStart(txSlotStart), .txSlot(txSlot), .txSlotMask(txSlotMask), .txSerEn(txSerEn),
    .txReady(txReady), .txBufFlat(txBufFlat),
    .rxCapture(rxCapture), .rxSlot(rxSlot), .rxSlotMask(rxSlotMask), .rxSerEn(rxSerEn),
    .rxBufIn(rxBufIn), .rxReady(rxReady),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun), .accessErr(accessErr),
    .txUnderrunClr(txUnderrunClr), .rxOverrunClr(rxOverrunClr), .accessErrClr(accessErrClr)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [NS*DW-1:0] act, input logic [NS*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mTx [NS];
  logic [DW-1:0] mRx [NS];
  int txQ[$];
  int rxQ[$];
  logic [DW-1:0] mRd;
  bit mRdV, mTxR, mRxR, mUnd, mOvr, mAcc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin mTx[i] = '0; mRx[i] = '0; end
      txQ.delete(); rxQ.delete();
      mRd = '0; mRdV = 0; mTxR = 0; mRxR = 0; mUnd = 0; mOvr = 0; mAcc = 0;
    end else begin
      bit und, ovr, acc;
      und = 0; ovr = 0; acc = 0;
      mTxR = txSlotStart;
      mRxR = rxCapture;
      mRdV = 0;
      if (!busSel && hostWrEn && !txSlotStart) begin
        if (txQ.size() > 0) mTx[txQ.pop_front()] = hostWrData;
        else acc = 1;
      end
      if (!busSel && hostRdEn && !rxCapture) begin
        mRdV = 1;
        if (rxQ.size() > 0) mRd = mRx[rxQ.pop_front()];
        else begin mRd = '0; acc = 1; end
      end
      if (txSlotStart) begin
        if (txQ.size() > 0) und = 1;
        txQ.delete();
        if (txSlotMask[txSlot])
          for (int i = 0; i < NS; i++) if (txSerEn[i]) txQ.push_back(i);
      end
      if (rxCapture) begin
        if (rxQ.size() > 0) ovr = 1;
        rxQ.delete();
        if (rxSlotMask[rxSlot])
          for (int i = 0; i < NS; i++)
            if (rxSerEn[i]) begin rxQ.push_back(i); mRx[i] = rxBufIn[i*DW +: DW]; end
      end
      mUnd = und ? 1'b1 : (txUnderrunClr ? 1'b0 : mUnd);
      mOvr = ovr ? 1'b1 : (rxOverrunClr ? 1'b0 : mOvr);
      mAcc = acc ? 1'b1 : (accessErrClr ? 1'b0 : mAcc);
    end
  end

  // compare every cycle, 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (rstN && !finished) begin
      logic [NS*DW-1:0] flat;
      for (int i = 0; i < NS; i++) flat[i*DW +: DW] = mTx[i];
      chk("R2 txBuf", txBufFlat, flat);
      chk("R1 rdValid", {{(NS*DW-1){1'b0}}, hostRdValid}, {{(NS*DW-1){1'b0}}, mRdV});
      chk("R3 rdData", {{(NS*DW-DW){1'b0}}, hostRdData}, {{(NS*DW-DW){1'b0}}, mRd});
      chk("R9 txReady", {{(NS*DW-1){1'b0}}, txReady}, {{(NS*DW-1){1'b0}}, mTxR});
      chk("R9 rxReady", {{(NS*DW-1){1'b0}}, rxReady}, {{(NS*DW-1){1'b0}}, mRxR});
      chk("R5 underrun", {{(NS*DW-1){1'b0}}, txUnderrun}, {{(NS*DW-1){1'b0}}, mUnd});
      chk("R6 overrun", {{(NS*DW-1){1'b0}}, rxOverrun}, {{(NS*DW-1){1'b0}}, mOvr});
      chk("R7 accessErr", {{(NS*DW-1){1'b0}}, accessErr}, {{(NS*DW-1){1'b0}}, mAcc});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic txStart(input logic [NS-1:0] en, input logic [NSLOT-1:0] msk, input logic [SW-1:0] s);
    @(negedge clk); txSerEn = en; txSlotMask = msk; txSlot = s; txSlotStart = 1'b1;
    @(negedge clk); txSlotStart = 1'b0;
  endtask

  task automatic rxStart(input logic [NS-1:0] en, input logic [NSLOT-1:0] msk, input logic [SW-1:0] s);
    @(negedge clk);
    rxSerEn = en; rxSlotMask = msk; rxSlot = s; rxCapture = 1'b1;
    for (int i = 0; i < NS; i++) rxBufIn[i*DW +: DW] = $urandom;
    @(negedge clk); rxCapture = 1'b0;
  endtask

  task automatic hostWrite(input logic [DW-1:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [DW-1:0] d);
    @(negedge clk); hostRdEn = 1'b1;
    @(negedge clk); hostRdEn = 1'b0; d = hostRdData;
  endtask

  task automatic pulseClr(input bit u, input bit o, input bit a);
    @(negedge clk); txUnderrunClr = u; rxOverrunClr = o; accessErrClr = a;
    @(negedge clk); txUnderrunClr = 0; rxOverrunClr = 0; accessErrClr = 0;
  endtask

  function automatic logic [NS*DW-1:0] b1(input logic v);
    return {{(NS*DW-1){1'b0}}, v};
  endfunction

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [DW-1:0] rd;
    logic [NS*DW-1:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 txBuf reset", txBufFlat, '0);
    chk("R11 flags reset", b1(txUnderrun | rxOverrun | accessErr | txReady | rxReady | hostRdValid), b1(1'b0));
    chk("R11 rdData reset", {{(NS*DW-DW){1'b0}}, hostRdData}, '0);

    // R2: serializers 1 and 3 active
    txStart(16'h000A, 8'hFF, 3'd2);
    hostWrite(32'hAAAA0001);
    hostWrite(32'hBBBB0003);
    chk("R2 ser1", {{(NS*DW-DW){1'b0}}, txBufFlat[1*DW +: DW]}, {{(NS*DW-DW){1'b0}}, 32'hAAAA0001});
    chk("R2 ser3", {{(NS*DW-DW){1'b0}}, txBufFlat[3*DW +: DW]}, {{(NS*DW-DW){1'b0}}, 32'hBBBB0003});
    chk("R1 write keeps ser0", {{(NS*DW-DW){1'b0}}, txBufFlat[0 +: DW]}, '0);

    // R3: serializers 0, 1, 3 read in order
    rxStart(16'h000B, 8'hFF, 3'd0);
    hostRead(rd); chk("R3 first ser0", {{(NS*DW-DW){1'b0}}, rd}, {{(NS*DW-DW){1'b0}}, rxBufIn[0*DW +: DW]});
    hostRead(rd); chk("R3 second ser1", {{(NS*DW-DW){1'b0}}, rd}, {{(NS*DW-DW){1'b0}}, rxBufIn[1*DW +: DW]});
    hostRead(rd); chk("R3 third ser3", {{(NS*DW-DW){1'b0}}, rd}, {{(NS*DW-DW){1'b0}}, rxBufIn[3*DW +: DW]});
    // R7: read beyond the set
    hostRead(rd); chk("R7 extra read zero", {{(NS*DW-DW){1'b0}}, rd}, '0);
    chk("R7 accessErr set", b1(accessErr), b1(1'b1));
    @(negedge clk); chk("R10 accessErr held", b1(accessErr), b1(1'b1));
    pulseClr(0, 0, 1);
    chk("R10 accessErr cleared", b1(accessErr), b1(1'b0));

    // R4: slot deselected, enables ignored
    txStart(16'hFFFF, 8'hFB, 3'd2);
    snap = txBufFlat;
    hostWrite(32'h12345678);
    chk("R4 no buffer change", txBufFlat, snap);
    chk("R4 write is access error", b1(accessErr), b1(1'b1));
    pulseClr(0, 0, 1);

    // R8: port disabled
    txStart(16'h0020, 8'hFF, 3'd1);
    @(negedge clk); busSel = 1'b1;
    hostWrite(32'hDEADBEEF);
    chk("R8 write ignored", txBufFlat, snap);
    @(negedge clk); hostRdEn = 1'b1;
    @(negedge clk); hostRdEn = 1'b0;
    chk("R8 no rdValid", b1(hostRdValid), b1(1'b0));
    chk("R8 no error", b1(accessErr), b1(1'b0));
    @(negedge clk); busSel = 1'b0;

    // R5 and R10 set-wins
    @(negedge clk); txSlotStart = 1'b1; txUnderrunClr = 1'b1;
    @(negedge clk); txSlotStart = 1'b0; txUnderrunClr = 1'b0;
    chk("R5 underrun on unwritten ser5", b1(txUnderrun), b1(1'b1));
    chk("R10 set wins over clear", b1(txUnderrun), b1(1'b1));
    pulseClr(1, 0, 0);
    chk("R10 underrun cleared", b1(txUnderrun), b1(1'b0));

    // R6: capture again without reads
    rxStart(16'h0100, 8'hFF, 3'd3);
    rxStart(16'h0100, 8'hFF, 3'd3);
    chk("R6 overrun set", b1(rxOverrun), b1(1'b1));
    pulseClr(0, 1, 0);

    // random sparse masks and access counts
    for (int it = 0; it < 80; it++) begin
      logic [NS-1:0] te, re;
      int nw, nr;
      te = NS'($urandom & $urandom);
      re = NS'($urandom & $urandom);
      @(negedge clk); busSel = ($urandom % 8 == 0);
      @(negedge clk);
      txSerEn = te; rxSerEn = re;
      txSlotMask = NSLOT'($urandom | $urandom); rxSlotMask = NSLOT'($urandom | $urandom);
      txSlot = SW'($urandom); rxSlot = SW'($urandom);
      txSlotStart = 1'b1; rxCapture = 1'b1;
      for (int i = 0; i < NS; i++) rxBufIn[i*DW +: DW] = $urandom;
      @(negedge clk); txSlotStart = 1'b0; rxCapture = 1'b0;
      nw = $countones(te) + int'($urandom % 3) - 1;
      nr = $countones(re) + int'($urandom % 3) - 1;
      for (int c = 0; c < NS + 2; c++) begin
        @(negedge clk);
        hostWrEn = (c < nw); hostWrData = $urandom;
        hostRdEn = (c < nr);
        txUnderrunClr = ($urandom % 6 == 0);
        rxOverrunClr = ($urandom % 6 == 0);
        accessErrClr = ($urandom % 6 == 0);
      end
      @(negedge clk);
      hostWrEn = 0; hostRdEn = 0; txUnderrunClr = 0; rxOverrunClr = 0; accessErrClr = 0;
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule